// File: doc/BRIEF.md
# Fixed-Latency Timestamp Resequencer

This block is the output stage of a switch whose cells cross several parallel layers. Each layer link delivers at most one cell per slot. The cells on different links can arrive out of their original order. Every cell carries the input port it entered on and the slot number of its arrival at the switch. The block stores the cells. It releases each one exactly a fixed number of slots after its arrival stamp. As a result, the cells leave on the single output line in the order in which they entered the switch, at no more than one cell per slot.

A free-running global slot counter is shared with the rest of the switch. All stamp arithmetic is done modulo the width of that counter. The counter must span at least twice the fixed latency, so a stamp never becomes ambiguous across a wrap. In any slot where no stored cell is due, the output line carries an idle slot. Two error pulses report cells that are thrown away on arrival and release slots that more than one cell claims.

Top module: `rseq_top`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `out_vld`, `err_drop` and `err_clash` are low.
- R2: A cell accepted with stamp T is due in the slot where `slot_now` equals (T + LATENCY) modulo 2^SLOT_W. In the cycle that follows that slot, `out_vld` is high and `out_stamp`, `out_port` and `out_data` equal the values the cell arrived with.
- R3: Cells reach the output in the order of their stamps, whatever their order of arrival on the links. A cycle whose preceding slot had no cell due shows `out_vld` low.
- R4: Every layer link can present a cell in the same slot, and all of those cells are accepted when their release slots differ and storage is free.
- R5: A cell is accepted only if (T + LATENCY − `slot_now`) modulo 2^SLOT_W lies between 1 and LATENCY. Any other cell is discarded: `err_drop` is high in the next cycle, and the cell never appears on the output.
- R6: If two or more stored cells are due in the same slot, `err_clash` and `out_vld` are high in the next cycle. All of those cells are removed, and only one of them is sent.
- R7: If no storage entry is free, an arriving cell is discarded, and `err_drop` is high in the next cycle. When several cells arrive in one slot, free entries go to the lower-numbered layers first.
- R8: Release timing is correct for stamps and release slots on either side of a wrap of the slot counter.
- R9: An entry freed by a release can take a new cell in the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_now | input | SLOT_W | Global slot counter |
| lay_vld | input | LAYERS | Cell present on each layer link |
| lay_port | input | LAYERS*PORT_W | Input port of each link's cell, link 0 in the low bits |
| lay_stamp | input | LAYERS*SLOT_W | Arrival slot stamp of each link's cell |
| lay_data | input | LAYERS*DATA_W | Payload of each link's cell |
| out_vld | output | 1 | Output line carries a cell |
| out_port | output | PORT_W | Input port of the released cell |
| out_stamp | output | SLOT_W | Arrival stamp of the released cell |
| out_data | output | DATA_W | Payload of the released cell |
| err_drop | output | 1 | A cell was discarded in the previous slot |
| err_clash | output | 1 | Several cells were due in the previous slot |

## Verification
The bench builds the block with three layers, LATENCY 8, eight storage entries and a 5-bit slot counter. With these values the counter wraps every 32 slots, so the run crosses the wrap many times. Eight entries are exactly the number of distinct release slots a latency of 8 allows, so storage can be filled and overflowed in three slots. A late stamp, an early stamp and a one-slot gap are also easy to place at the edges of the acceptance window.

// File: rtl/rseq_pkg.sv
`timescale 1ns/1ps
package rseq_pkg;
  // index width that stays at least one bit for a count of one
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rseq_rst_sync.sv
`timescale 1ns/1ps
module rseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/rseq_alloc.sv
`timescale 1ns/1ps
module rseq_alloc #(
  parameter int unsigned LAYERS = 3,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IW    = rseq_pkg::idx_w(DEPTH)
) (
  input  logic [DEPTH-1:0]  free_mask,
  input  logic [LAYERS-1:0] req,
  output logic [LAYERS-1:0] gnt,
  output logic [IW-1:0]     sel [LAYERS]
);
  logic [DEPTH-1:0] taken;

  // lower layers claim the lowest free entries first
  always_comb begin
    taken = '0;
    gnt   = '0;
    for (int k = 0; k < LAYERS; k++) begin
      sel[k] = '0;
      for (int d = 0; d < DEPTH; d++) begin
        if (req[k] && !gnt[k] && free_mask[d] && !taken[d]) begin
          gnt[k]   = 1'b1;
          sel[k]   = IW'(d);
          taken[d] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rseq_pick.sv
`timescale 1ns/1ps
module rseq_pick #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW   = rseq_pkg::idx_w(DEPTH)
) (
  input  logic [DEPTH-1:0] hit,
  output logic             any,
  output logic             multi,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int d = DEPTH - 1; d >= 0; d--) begin
      if (hit[d]) idx = IW'(d);
    end
    any   = |hit;
    multi = ($countones(hit) > 1);
  end
endmodule

// File: rtl/rseq_top.sv
`timescale 1ns/1ps
module rseq_top #(
  parameter int unsigned LAYERS  = 3,
  parameter int unsigned LATENCY = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned PORT_W  = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOT_W-1:0]        slot_now,
  input  logic [LAYERS-1:0]        lay_vld,
  input  logic [LAYERS*PORT_W-1:0] lay_port,
  input  logic [LAYERS*SLOT_W-1:0] lay_stamp,
  input  logic [LAYERS*DATA_W-1:0] lay_data,
  output logic                     out_vld,
  output logic [PORT_W-1:0]        out_port,
  output logic [SLOT_W-1:0]        out_stamp,
  output logic [DATA_W-1:0]        out_data,
  output logic                     err_drop,
  output logic                     err_clash
);
  localparam int unsigned IW = rseq_pkg::idx_w(DEPTH);
  localparam int unsigned KW = rseq_pkg::idx_w(LAYERS);
  localparam logic [SLOT_W-1:0] LAT_S = SLOT_W'(LATENCY);

  logic rst_q;

  // storage
  logic [DEPTH-1:0]  ent_vld, ent_vld_n;
  logic [SLOT_W-1:0] ent_rel  [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  // arrival side
  logic [SLOT_W-1:0] arr_rel [LAYERS];
  logic [SLOT_W-1:0] arr_gap [LAYERS];
  logic [LAYERS-1:0] arr_ok, gnt;
  logic [IW-1:0]     sel [LAYERS];
  logic [DEPTH-1:0]  wen;
  logic [KW-1:0]     wsrc [DEPTH];

  // release side
  logic [DEPTH-1:0]  hit;
  logic              rel_any, rel_multi;
  logic [IW-1:0]     rel_idx;

  rseq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // window check: due strictly after this slot and no further than LATENCY away
  for (genvar k = 0; k < LAYERS; k++) begin : g_arr
    assign arr_rel[k] = lay_stamp[k*SLOT_W +: SLOT_W] + LAT_S;
    assign arr_gap[k] = arr_rel[k] - slot_now;
    assign arr_ok[k]  = lay_vld[k] && (arr_gap[k] != '0) && (arr_gap[k] <= LAT_S);
  end

  rseq_alloc #(.LAYERS(LAYERS), .DEPTH(DEPTH)) u_alloc (
    .free_mask(~ent_vld),
    .req      (arr_ok),
    .gnt      (gnt),
    .sel      (sel)
  );

  for (genvar d = 0; d < DEPTH; d++) begin : g_hit
    assign hit[d] = ent_vld[d] && (ent_rel[d] == slot_now);
  end

  rseq_pick #(.DEPTH(DEPTH)) u_pick (
    .hit  (hit),
    .any  (rel_any),
    .multi(rel_multi),
    .idx  (rel_idx)
  );

  // next state of the entry valid bits and write steering
  always_comb begin
    ent_vld_n = ent_vld & ~hit;
    wen       = '0;
    for (int d = 0; d < DEPTH; d++) wsrc[d] = '0;
    for (int k = 0; k < LAYERS; k++) begin
      if (gnt[k]) begin
        ent_vld_n[sel[k]] = 1'b1;
        wen[sel[k]]       = 1'b1;
        wsrc[sel[k]]      = KW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ent_vld   <= '0;
      out_vld   <= 1'b0;
      err_drop  <= 1'b0;
      err_clash <= 1'b0;
    end else begin
      ent_vld   <= ent_vld_n;
      out_vld   <= rel_any;
      err_drop  <= |(lay_vld & ~gnt);
      err_clash <= rel_multi;
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wen[d]) begin
        ent_rel[d]  <= arr_rel[wsrc[d]];
        ent_port[d] <= lay_port[wsrc[d]*PORT_W +: PORT_W];
        ent_data[d] <= lay_data[wsrc[d]*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rel_any) begin
      out_port  <= ent_port[rel_idx];
      out_stamp <= ent_rel[rel_idx] - LAT_S;
      out_data  <= ent_data[rel_idx];
    end
  end
endmodule

// File: rtl/rseq_chk.sv
`timescale 1ns/1ps
module rseq_chk #(
  parameter int unsigned LAYERS  = 3,
  parameter int unsigned LATENCY = 8,
  parameter int unsigned SLOT_W  = 5
) (
  input logic                     clk,
  input logic                     rst_q,
  input logic [SLOT_W-1:0]        slot_now,
  input logic [LAYERS-1:0]        lay_vld,
  input logic [LAYERS*SLOT_W-1:0] lay_stamp,
  input logic                     out_vld,
  input logic [SLOT_W-1:0]        out_stamp,
  input logic                     err_drop,
  input logic                     err_clash
);
  localparam logic [SLOT_W-1:0] LAT_S = SLOT_W'(LATENCY);

  // R2
  release_slot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_vld |-> (SLOT_W'(out_stamp + LAT_S) == $past(slot_now)));

  // R6
  clash_sends_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err_clash |-> out_vld);

  // R5
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err_drop |-> ($past(lay_vld) != '0));

  // R5
  late_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (lay_vld[0] && (SLOT_W'(lay_stamp[SLOT_W-1:0] + LAT_S) == slot_now)) |=> err_drop);
endmodule

bind rseq_top rseq_chk #(.LAYERS(LAYERS), .LATENCY(LATENCY), .SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .slot_now (slot_now),
  .lay_vld  (lay_vld),
  .lay_stamp(lay_stamp),
  .out_vld  (out_vld),
  .out_stamp(out_stamp),
  .err_drop (err_drop),
  .err_clash(err_clash)
);

// File: tb/rseq_top_bench.sv
`timescale 1ns/1ps
module rseq_top_bench;
  localparam int K = 3, L = 8, D = 8, SW = 5, PW = 2, DW = 8;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0]   slot_now = '0;
  logic [K-1:0]    lay_vld = '0;
  logic [K*PW-1:0] lay_port = '0;
  logic [K*SW-1:0] lay_stamp = '0;
  logic [K*DW-1:0] lay_data = '0;
  logic out_vld, err_drop, err_clash;
  logic [PW-1:0] out_port;
  logic [SW-1:0] out_stamp;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  rseq_top #(.LAYERS(K), .LATENCY(L), .DEPTH(D), .SLOT_W(SW), .PORT_W(PW), .DATA_W(DW))
  u_rseq_top (.*);

  int nchk = 0, nfail = 0;
  int cur = 0, occ = 0;
  int cnt [NS];
  logic [PW-1:0] e_port [NS];
  logic [DW-1:0] e_data [NS];
  bit drop_now = 0;
  bit done = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (slot %0d)", rq, act, exp, cur);
    end
  endtask

  // present one cell on a layer in the current slot and update the model
  task automatic put(input int ly, input int port, input int stamp, input int data);
    int rel, gap;
    rel = (stamp + L) % NS;
    gap = (rel - cur + NS) % NS;
    lay_vld[ly] = 1'b1;
    lay_port[ly*PW +: PW] = PW'(port);
    lay_stamp[ly*SW +: SW] = SW'(stamp % NS);
    lay_data[ly*DW +: DW] = DW'(data);
    if (gap < 1 || gap > L || occ >= D) drop_now = 1;
    else begin
      occ++;
      cnt[rel]++;
      e_port[rel] = PW'(port);
      e_data[rel] = DW'(data);
    end
  endtask

  // one slot: edge, then compare outputs against the model for the slot just closed
  task automatic tick(input string rq);
    @(posedge clk);
    @(negedge clk);
    check(out_vld == (cnt[cur] > 0), rq, out_vld, cnt[cur] > 0);
    check(err_drop == drop_now, {rq, "/R5/R7 drop"}, err_drop, drop_now);
    check(err_clash == (cnt[cur] > 1), {rq, "/R6 clash"}, err_clash, cnt[cur] > 1);
    if (cnt[cur] == 1) begin
      check(out_data == e_data[cur], {rq, " R2 data"}, out_data, e_data[cur]);
      check(out_port == e_port[cur], {rq, " R2 port"}, out_port, e_port[cur]);
      check(int'(out_stamp) == (cur - L + NS) % NS, {rq, " R2 stamp"}, out_stamp, (cur - L + NS) % NS);
    end
    occ -= cnt[cur];
    cnt[cur] = 0;
    drop_now = 0;
    lay_vld = '0;
    cur = (cur + 1) % NS;
    slot_now = SW'(cur);
  endtask

  task automatic drain(input string rq);
    for (int i = 0; i < L + 2; i++) tick(rq);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NS; i++) cnt[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_vld && !err_drop && !err_clash, "R1 in reset", {out_vld, err_drop, err_clash}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_vld && !err_drop && !err_clash, "R1 after reset", {out_vld, err_drop, err_clash}, 0);
  endtask

  task automatic t_single();
    put(0, 1, cur, 8'h11);
    tick("R2 single");
    put(1, 2, cur - 3 + NS, 8'h22);
    drain("R2 single");
  endtask

  task automatic t_reorder();
    put(2, 3, cur - 5 + NS, 8'h31);
    put(0, 0, cur, 8'h32);
    put(1, 1, cur - 2 + NS, 8'h33);
    tick("R3 reorder");
    put(0, 2, cur - 7 + NS, 8'h34);
    tick("R3 reorder");
    drain("R3 reorder");
  endtask

  task automatic t_multi();
    put(0, 0, cur, 8'h41);
    put(1, 1, cur - 1 + NS, 8'h42);
    put(2, 2, cur - 2 + NS, 8'h43);
    tick("R4 all layers");
    drain("R4 all layers");
  endtask

  task automatic t_late();
    put(0, 1, cur + 1, 8'h51);        // window gap L+1
    put(1, 2, cur - L + NS, 8'h52);   // gap 0: due now
    tick("R5 late/early");
    put(2, 3, cur - L - 1 + NS, 8'h53); // already past
    drain("R5 late/early");
  endtask

  task automatic t_clash();
    put(0, 1, cur - 2 + NS, 8'h61);
    put(2, 2, cur - 2 + NS, 8'h62);
    drain("R6 clash");
  endtask

  task automatic t_full();
    int c;
    c = cur;
    put(0, 0, c, 8'h71); put(1, 1, c - 1 + NS, 8'h72); put(2, 2, c - 2 + NS, 8'h73);
    tick("R7 fill");
    put(0, 3, c + 1, 8'h74); put(1, 0, c - 3 + NS, 8'h75); put(2, 1, c - 4 + NS, 8'h76);
    tick("R7 fill");
    put(0, 2, c + 2, 8'h77); put(1, 3, c - 5 + NS, 8'h78); put(2, 0, c + 1, 8'h79);
    tick("R7 overflow");
    // entry freed at slot c+3 release, reused in the following slot
    tick("R9 free");
    put(0, 1, cur, 8'h7a);
    drain("R9 reuse");
  endtask

  task automatic t_wrap();
    while (cur != NS - 3) tick("R8 idle");
    put(0, 1, cur, 8'h81);            // due after the wrap
    put(1, 2, cur - 6 + NS, 8'h82);   // due just before the wrap
    tick("R8 wrap");
    tick("R8 wrap");
    put(2, 3, cur, 8'h83);            // stamp right at the wrap
    drain("R8 wrap");
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_reorder();
    t_multi();
    t_late();
    t_clash();
    t_full();
    t_wrap();
    t_reorder();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule